// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

When a transfer is cut off partway, a slave can be left holding SDA low, waiting for clock edges that will never come. This sequencer frees such a bus. On a start request it first gives the I2C controller time to finish: it waits, a phase at a time, for the controller busy flag to drop. When that wait ends it decides whether recovery is needed. Recovery is needed only if the busy flag is still set or SDA is sampled low. If no recovery is needed, the sequencer signals done at once and never touches the pins.

When recovery is armed, the sequencer takes the pins from the controller and masks the controller's own pull-downs. It pulls SCL low for one phase. It then clocks SCL, one phase high and one phase low per pulse. SDA is sampled before each pulse. Clocking stops as soon as SDA reads high, or once the pulse cap is reached. SCL is then released and held high for one more phase. After that the pins go back to the controller, and done pulses for one cycle. Failed pulses with done if SDA was still low after the last allowed pulse.

A phase is a programmable number of pulses of the `tick_i` input, so a slow time base or a short test phase can drive the same logic. Generating a STOP condition on SDA is left to the controller.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, own_o, done_o and failed_o are 0, and both pad pull-down outputs equal the controller's pull-down inputs.
- R2: go_i is acted on only while the sequencer is idle. A go_i pulse during the wait or recovery neither restarts the run nor adds a second done_o pulse.
- R3: After an accepted go_i, the sequencer waits while busy_i is 1. The wait ends in the first cycle busy_i is 0, or after BUSY_PHASES full phases if busy_i stays 1.
- R4: At the end of the wait, recovery is armed only if busy_i is 1 or sda_i is 0. Otherwise done_o pulses with failed_o = 0, and own_o stays 0 throughout.
- R5: When armed, own_o goes to 1 with SCL pulled low (pad_scl_lo_o = 1), and SCL stays low for one phase before any pulse.
- R6: Each pulse is SCL released (pad_scl_lo_o = 0) for one phase, then pulled low for one phase. sda_i is sampled at the end of the initial low phase and at the end of every pulse's low phase. A 1 there ends the pulsing.
- R7: At most MAX_PULSES pulses are issued. If sda_i is still 0 at the sample after the last pulse, failed_o is 1 in the same cycle as done_o. Otherwise failed_o stays 0.
- R8: After pulsing, SCL is released for one phase with own_o still 1. Then own_o drops to 0, and done_o is 1 for exactly that one cycle.
- R9: A phase lasts PHASE_TICKS cycles in which tick_i is 1. In cycles where tick_i is 0, the sequencer holds its state and outputs.
- R10: While own_o is 0, pad_scl_lo_o follows ctl_scl_lo_i and pad_sda_lo_o follows ctl_sda_lo_i. While own_o is 1, the controller inputs are masked and pad_sda_lo_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start request, one cycle |
| busy_i | input | 1 | Controller busy flag |
| sda_i | input | 1 | Synchronized SDA level |
| tick_i | input | 1 | Time base; a phase is PHASE_TICKS ticks |
| ctl_scl_lo_i | input | 1 | Controller SCL pull-down request |
| ctl_sda_lo_i | input | 1 | Controller SDA pull-down request |
| pad_scl_lo_o | output | 1 | SCL pad pull-down enable |
| pad_sda_lo_o | output | 1 | SDA pad pull-down enable |
| own_o | output | 1 | Sequencer owns the pins |
| done_o | output | 1 | Run finished, one cycle |
| failed_o | output | 1 | SDA still low after the pulse cap, with done_o |

## Verification
The bench attacks the loop bounds and the exit sample. A slave model releases SDA after a chosen number of SCL rising edges. An off-by-one in the exit sample would show up as one pulse too many or too few. A slave that never releases SDA tests the cap: a design with a wrong cap gives a pulse count other than ten, or a missing failed flag. A busy flag held high must still arm recovery after the timeout, even with SDA high. A design that judged only SDA would skip recovery there. Holding the tick low mid-wait and toggling the controller pull-downs every cycle expose timers that run free and controller drive that leaks through while the sequencer owns the pins.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_PRE  = 3'd2,
        ST_HIGH = 3'd3,
        ST_LOW  = 3'd4,
        ST_REL  = 3'd5,
        ST_DONE = 3'd6
    } seq_state_e;
endpackage

// File: rtl/unstick_phase_timer.sv
module unstick_phase_timer #(
    parameter int PHASE_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic phase_end_o
);
    localparam int TW = $clog2(PHASE_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(PHASE_TICKS - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign phase_end_o = tick_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !tick_i) |=> $stable(cnt_q)); // R9
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R9
endmodule

// File: rtl/unstick_ctrl.sv
module unstick_ctrl
    import unstick_pkg::*;
#(
    parameter int BUSY_PHASES = 1000,
    parameter int MAX_PULSES  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic busy_i,
    input  logic sda_i,
    input  logic pend_i,
    output logic clr_o,
    output logic own_o,
    output logic scl_lo_o,
    output logic done_o,
    output logic failed_o
);
    localparam int BW = $clog2(BUSY_PHASES + 1);
    localparam int CW = $clog2(MAX_PULSES + 1);
    localparam logic [BW-1:0] BUSY_LAST = BW'(BUSY_PHASES - 1);
    localparam logic [CW-1:0] PULSE_CAP = CW'(MAX_PULSES);

    typedef struct packed {
        seq_state_e     st;
        logic [BW-1:0]  bcnt;
        logic [CW-1:0]  pcnt;
        logic           fail;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic  wait_over;

    always_comb begin
        st_d      = st_q;
        wait_over = !busy_i || (pend_i && (st_q.bcnt == BUSY_LAST));
        case (st_q.st)
            ST_IDLE: begin
                if (go_i) begin
                    st_d.st   = ST_WAIT;
                    st_d.bcnt = '0;
                end
            end
            ST_WAIT: begin
                if (wait_over) begin
                    if (busy_i || !sda_i) begin
                        st_d.st   = ST_PRE;
                        st_d.pcnt = '0;
                    end else begin
                        st_d.st   = ST_DONE;
                        st_d.fail = 1'b0;
                    end
                end else if (pend_i) begin
                    st_d.bcnt = st_q.bcnt + 1'b1;
                end
            end
            ST_PRE, ST_LOW: begin
                if (pend_i) begin
                    if (sda_i) begin
                        st_d.st   = ST_REL;
                        st_d.fail = 1'b0;
                    end else if (st_q.pcnt == PULSE_CAP) begin
                        st_d.st   = ST_REL;
                        st_d.fail = 1'b1;
                    end else begin
                        st_d.st   = ST_HIGH;
                        st_d.pcnt = st_q.pcnt + 1'b1;
                    end
                end
            end
            ST_HIGH: if (pend_i) st_d.st = ST_LOW;
            ST_REL:  if (pend_i) st_d.st = ST_DONE;
            ST_DONE: st_d.st = ST_IDLE;
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, bcnt: '0, pcnt: '0, fail: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign clr_o    = (st_d.st != st_q.st) || (st_q.st == ST_IDLE);
    assign own_o    = (st_q.st == ST_PRE) || (st_q.st == ST_HIGH) ||
                      (st_q.st == ST_LOW) || (st_q.st == ST_REL);
    assign scl_lo_o = (st_q.st == ST_PRE) || (st_q.st == ST_LOW);
    assign done_o   = (st_q.st == ST_DONE);
    assign failed_o = done_o && st_q.fail;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_FAIL_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        failed_o |-> done_o); // R7
    AST_FAIL_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        failed_o |-> (st_q.pcnt == PULSE_CAP)); // R7
    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pcnt <= PULSE_CAP); // R7
    AST_ENTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_o) |-> scl_lo_o); // R5
    AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o && go_i) |=> (own_o || done_o)); // R2
endmodule

// File: rtl/unstick_pin_mux.sv
module unstick_pin_mux (
    input  logic own_i,
    input  logic seq_scl_lo_i,
    input  logic ctl_scl_lo_i,
    input  logic ctl_sda_lo_i,
    output logic pad_scl_lo_o,
    output logic pad_sda_lo_o
);
    always_comb begin
        if (own_i) begin
            pad_scl_lo_o = seq_scl_lo_i;
            pad_sda_lo_o = 1'b0;
        end else begin
            pad_scl_lo_o = ctl_scl_lo_i;
            pad_sda_lo_o = ctl_sda_lo_i;
        end
    end
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick #(
    parameter int PHASE_TICKS = 1000,
    parameter int BUSY_PHASES = 1000,
    parameter int MAX_PULSES  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic busy_i,
    input  logic sda_i,
    input  logic tick_i,
    input  logic ctl_scl_lo_i,
    input  logic ctl_sda_lo_i,
    output logic pad_scl_lo_o,
    output logic pad_sda_lo_o,
    output logic own_o,
    output logic done_o,
    output logic failed_o
);
    logic phase_end, tmr_clr, seq_scl_lo;

    unstick_phase_timer #(.PHASE_TICKS(PHASE_TICKS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (tmr_clr),
        .tick_i      (tick_i),
        .phase_end_o (phase_end)
    );

    unstick_ctrl #(.BUSY_PHASES(BUSY_PHASES), .MAX_PULSES(MAX_PULSES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go_i),
        .busy_i   (busy_i),
        .sda_i    (sda_i),
        .pend_i   (phase_end),
        .clr_o    (tmr_clr),
        .own_o    (own_o),
        .scl_lo_o (seq_scl_lo),
        .done_o   (done_o),
        .failed_o (failed_o)
    );

    unstick_pin_mux u_mux (
        .own_i        (own_o),
        .seq_scl_lo_i (seq_scl_lo),
        .ctl_scl_lo_i (ctl_scl_lo_i),
        .ctl_sda_lo_i (ctl_sda_lo_i),
        .pad_scl_lo_o (pad_scl_lo_o),
        .pad_sda_lo_o (pad_sda_lo_o)
    );

    AST_SDA_FREE_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        own_o |-> !pad_sda_lo_o); // R10
    AST_CTL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !own_o |-> (pad_scl_lo_o == ctl_scl_lo_i && pad_sda_lo_o == ctl_sda_lo_i)); // R10
    AST_RELEASE_BEFORE_HANDBACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_o) |-> done_o); // R8
endmodule

// File: tb/sim_i2c_unstick.sv
`timescale 1ns/1ps
module sim_i2c_unstick;
    localparam int P = 3;
    localparam int B = 5;
    localparam int M = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go_i = 1'b0, busy_i = 1'b0, sda_i = 1'b1, tick_i = 1'b1;
    logic ctl_scl_lo_i = 1'b0, ctl_sda_lo_i = 1'b0;
    logic pad_scl_lo_o, pad_sda_lo_o, own_o, done_o, failed_o;

    always #4 clk = ~clk;

    i2c_unstick #(.PHASE_TICKS(P), .BUSY_PHASES(B), .MAX_PULSES(M)) u0 (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .busy_i(busy_i), .sda_i(sda_i),
        .tick_i(tick_i), .ctl_scl_lo_i(ctl_scl_lo_i), .ctl_sda_lo_i(ctl_sda_lo_i),
        .pad_scl_lo_o(pad_scl_lo_o), .pad_sda_lo_o(pad_sda_lo_o),
        .own_o(own_o), .done_o(done_o), .failed_o(failed_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model: 0 idle, 1 wait, 2 low before pulsing, 3 scl high,
    // 4 scl low, 5 release, 6 finished
    int m_mode = 0, m_tick = 0, m_busy = 0, m_pulses = 0;
    bit m_fail = 0;

    always @(posedge clk) begin
        int nxt;
        bit ph;
        if (!rst_n) begin
            m_mode = 0; m_tick = 0; m_busy = 0; m_pulses = 0; m_fail = 0;
        end else begin
            ph  = tick_i && (m_tick == P - 1);
            nxt = m_mode;
            if (m_mode == 0) begin
                if (go_i) begin nxt = 1; m_busy = 0; end
            end else if (m_mode == 1) begin
                if (!busy_i || (ph && m_busy == B - 1)) begin
                    if (busy_i || !sda_i) begin nxt = 2; m_pulses = 0; end
                    else begin nxt = 6; m_fail = 0; end
                end else if (ph) m_busy++;
            end else if (m_mode == 2 || m_mode == 4) begin
                if (ph) begin
                    if (sda_i) begin nxt = 5; m_fail = 0; end
                    else if (m_pulses == M) begin nxt = 5; m_fail = 1; end
                    else begin nxt = 3; m_pulses++; end
                end
            end else if (m_mode == 3) begin
                if (ph) nxt = 4;
            end else if (m_mode == 5) begin
                if (ph) nxt = 6;
            end else begin
                nxt = 0;
            end
            if (nxt != m_mode || m_mode == 0) m_tick = 0;
            else if (tick_i) m_tick = ph ? 0 : m_tick + 1;
            m_mode = nxt;
        end
    end

    // Slave, controller activity, statistics
    int need = 0, base = 0, rise_total = 0;
    int rises = 0, own_cyc = 0, done_cnt = 0, fail_cnt = 0;
    bit prev_hi = 1'b1;
    bit tick_alt = 1'b0;

    always @(negedge clk) begin
        bit hi;
        cyc++;
        hi = !pad_scl_lo_o;
        if (own_o && hi && !prev_hi) begin
            rise_total++;
            rises++;
        end
        prev_hi = hi;
        sda_i = ((rise_total - base) >= need);
        ctl_scl_lo_i = cyc[0];
        ctl_sda_lo_i = cyc[2];
        if (tick_alt) tick_i = cyc[0];
        if (own_o) own_cyc++;
        if (done_o) done_cnt++;
        if (failed_o) fail_cnt++;
    end

    // Per-cycle comparison against the model
    always begin
        bit e_own, e_scl, e_sda, e_done, e_fail;
        @(negedge clk);
        #2;
        if (rst_n) begin
            e_own  = (m_mode >= 2 && m_mode <= 5);
            e_scl  = e_own ? (m_mode == 2 || m_mode == 4) : ctl_scl_lo_i;
            e_sda  = e_own ? 1'b0 : ctl_sda_lo_i;
            e_done = (m_mode == 6);
            e_fail = e_done && m_fail;
            chk(own_o == e_own, "R5 own_o", own_o, e_own);
            chk(pad_scl_lo_o == e_scl, "R6 pad_scl_lo_o", pad_scl_lo_o, e_scl);
            chk(pad_sda_lo_o == e_sda, "R10 pad_sda_lo_o", pad_sda_lo_o, e_sda);
            chk(done_o == e_done, "R8 done_o", done_o, e_done);
            chk(failed_o == e_fail, "R7 failed_o", failed_o, e_fail);
        end
    end

    task automatic clear_stats();
        rises = 0; own_cyc = 0; done_cnt = 0; fail_cnt = 0;
    endtask

    task automatic set_slave(input int n);
        @(negedge clk);
        base = rise_total;
        need = n;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_go();
        @(negedge clk); go_i = 1'b1;
        @(negedge clk); go_i = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        int n = 0;
        while (done_cnt == 0 && n < limit) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(own_o == 1'b0 && done_o == 1'b0 && failed_o == 1'b0, "R1 reset outputs",
            {own_o, done_o, failed_o}, 0);
        chk(pad_scl_lo_o == ctl_scl_lo_i && pad_sda_lo_o == ctl_sda_lo_i,
            "R1 reset pass-through", {pad_scl_lo_o, pad_sda_lo_o},
            {ctl_scl_lo_i, ctl_sda_lo_i});
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Bus already free: no ownership, clean done
        set_slave(0); busy_i = 1'b0; clear_stats();
        pulse_go(); wait_done(200);
        chk(own_cyc == 0, "R4 free bus never owned", own_cyc, 0);
        chk(done_cnt == 1 && fail_cnt == 0, "R4 free bus done", done_cnt*10 + fail_cnt, 10);

        // Slave releases after three clocks
        set_slave(3); clear_stats();
        pulse_go(); wait_done(400);
        chk(rises == 4, "R6 three pulses plus release", rises, 4);
        chk(own_cyc == 8 * P, "R5 owned phases", own_cyc, 8 * P);
        chk(fail_cnt == 0, "R7 no failure on release", fail_cnt, 0);

        // Slave never releases; a stray go mid-run
        set_slave(1000); clear_stats();
        pulse_go();
        repeat (10 * P) @(negedge clk);
        pulse_go();
        wait_done(800);
        chk(rises == M + 1, "R7 pulse cap", rises, M + 1);
        chk(fail_cnt == 1, "R7 failed with done", fail_cnt, 1);
        chk(done_cnt == 1, "R2 single done despite second go", done_cnt, 1);

        // Busy stuck, SDA high: timeout then armed, no pulses
        set_slave(0); busy_i = 1'b1; clear_stats();
        pulse_go(); wait_done(400);
        chk(own_cyc == 2 * P, "R3 timeout arms recovery", own_cyc, 2 * P);
        chk(rises == 1, "R4 busy arms with SDA high", rises, 1);

        // Busy clears mid-wait with SDA high
        clear_stats();
        pulse_go();
        repeat (4) @(negedge clk);
        busy_i = 1'b0;
        wait_done(200);
        chk(own_cyc == 0 && done_cnt == 1, "R3 busy drop ends wait", own_cyc, 0);

        // Tick held low stalls the wait
        busy_i = 1'b1; clear_stats();
        @(negedge clk); tick_i = 1'b0;
        pulse_go();
        repeat (40) @(negedge clk);
        chk(done_cnt == 0 && own_cyc == 0, "R9 no progress without tick", done_cnt + own_cyc, 0);
        tick_i = 1'b1;
        busy_i = 1'b0;
        set_slave(2);
        wait_done(300);
        chk(done_cnt == 1, "R9 resumes with tick", done_cnt, 1);

        // Sparse tick with a stuck SDA for two clocks
        set_slave(2); clear_stats(); tick_alt = 1'b1;
        pulse_go(); wait_done(800);
        tick_alt = 1'b0; tick_i = 1'b1;
        chk(rises == 3 && done_cnt == 1, "R9 sparse tick pulses", rises, 3);
        chk(own_o == 1'b0, "R10 pins handed back", own_o, 0);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule